// File: doc/BRIEF.md
# Threshold-Triggered Stream Capture Unit

This block watches a continuous stream of two-channel samples. Each 32-bit beat packs two signed 16-bit channels. Once software arms it, the block compares both channels of every incoming beat against a signed threshold. On the first beat where either channel is strictly greater than the threshold, it sends one single-cycle pulse to an external waveform generator. It then collects a fixed-length burst of the beats that follow and forwards them on an AXI4-Stream master toward a DMA engine.

The input side never stalls. `s_tready` is tied high, so the upstream converter cannot back up while the block waits for an arm or for the DMA. A FIFO inside the block absorbs backpressure on the output side. If the FIFO is sized at least as deep as the burst, no captured beat is lost.

Software has to arm the block only after the DMA has been started. The DMA's own ready signal after reset is not a reliable sign that it will accept data.

The controller has four states:

| State | Meaning |
|---|---|
| IDLE | Not busy. Input beats are discarded. |
| ARMED | Comparing each beat against the threshold. |
| CAPTURE | Writing burst beats into the FIFO. |
| DRAIN | Waiting for the FIFO to empty onto the output. |

The transitions between them are:

| Transition | Condition |
|---|---|
| `arm_accept` (IDLE to ARMED) | `arm` is high. |
| `cross_hit` (ARMED to CAPTURE) | A valid beat crosses the threshold. |
| `burst_done` (CAPTURE to DRAIN) | The last burst beat is stored or dropped. |
| `drain_done` (DRAIN to IDLE) | The final beat leaves the output interface. |

Top module: `thresh_capture`

## Requirements
- R1: `s_tready` is high in every cycle after reset, whatever the state and whatever `m_tready` does.
- R2: An `arm` pulse in IDLE makes `busy` high in the next cycle and clears `overflow`. An `arm` while `busy` is high is ignored, and `overflow` keeps its value.
- R3: In ARMED, consider a valid beat where either channel A (bits 15:0) or channel B (bits 31:16), taken as signed, is strictly greater than the signed `threshold`. After such a beat, `trig_pulse` is high for exactly one cycle, and that cycle is the one right after the beat is accepted. A channel equal to the threshold does not trigger.
- R4: Threshold crossings in IDLE, CAPTURE or DRAIN produce no pulse. One armed capture yields exactly one pulse.
- R5: The `BURST_LEN` valid beats after the triggering beat appear on `m_tdata`, in order and unchanged. The triggering beat itself is not forwarded, and beats that arrive after the burst are not forwarded.
- R6: `m_tlast` is high on the `BURST_LEN`-th output beat of a capture and on no other beat.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` and `m_tdata` hold their values. With `FIFO_DEPTH` ≥ `BURST_LEN`, any `m_tready` pattern delivers the whole burst and leaves `overflow` low.
- R8: A burst beat that arrives while the FIFO is full is dropped and sets the sticky `overflow` flag. When the dropped beat was the last one, no beat carries `m_tlast`, but the capture still ends once the FIFO has drained.
- R9: `busy` falls in the cycle after the final stored beat is accepted on the output. A crossing after that point has no effect until a new `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start request from software, sampled in IDLE |
| threshold | input | 16 | Signed trigger level |
| s_tdata | input | 32 | Input beat: {channel B, channel A} |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Always high |
| m_tdata | output | 32 | Forwarded beat |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Sink accepts beat |
| m_tlast | output | 1 | Final beat of the burst |
| trig_pulse | output | 1 | One-cycle trigger to the waveform generator |
| busy | output | 1 | High from arm acceptance until the burst has drained |
| overflow | output | 1 | Sticky: a burst beat was dropped |

## Verification
The bench builds the block with `BURST_LEN` = 12 and `FIFO_DEPTH` = 8. Keeping the FIFO shallower than the burst makes the overflow path reachable just by holding `m_tready` low, including the case where the last beat is dropped. When `m_tready` is kept free or toggling, the same small configuration still finishes full captures in a few dozen cycles. That leaves room to sweep five thresholds, covering negative, zero and positive levels. For each threshold the bench tries sample values from two below to two above it on each channel, and each sweep point runs a complete capture.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DRAIN   = 2'd3
    } cap_state_e;

    localparam int CH_W   = 16;
    localparam int BEAT_W = 2 * CH_W;

    typedef struct packed {
        logic              last;
        logic [BEAT_W-1:0] data;
    } fifo_word_t;

endpackage

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH):0]       level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW:0]   wr_q, rd_q;

    assign level = wr_q - rd_q;
    assign full  = (level == (AW+1)'(DEPTH));
    assign empty = (level == '0);
    assign dout  = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    // R8: the controller must never write into a full FIFO
    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tcap_detect.sv
module tcap_detect #(
    parameter int CW = 16
) (
    input  logic              valid,
    input  logic [2*CW-1:0]   beat,
    input  logic [CW-1:0]     level,
    output logic              hit
);
    logic signed [CW-1:0] ch_a, ch_b, lvl;

    always_comb begin
        ch_a = beat[CW-1:0];
        ch_b = beat[2*CW-1:CW];
        lvl  = level;
        hit  = valid && ((ch_a > lvl) || (ch_b > lvl));
    end
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
    import tcap_pkg::*;
#(
    parameter int BURST_LEN = 2000,
    parameter int LVL_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             s_valid,
    input  logic             hit,
    input  logic             fifo_full,
    input  logic             fifo_pop,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             push,
    output logic             push_last,
    output logic             trig_pulse,
    output logic             busy,
    output logic             overflow
);
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             beat_in, drop, final_beat;
    logic             trig_q, ovf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm)                       state_d = ST_ARMED;   // arm_accept
            ST_ARMED:   if (hit)                       state_d = ST_CAPTURE; // cross_hit
            ST_CAPTURE: if (beat_in && cnt_q == LAST_IDX) state_d = ST_DRAIN; // burst_done
            ST_DRAIN:   if (final_beat)                state_d = ST_IDLE;    // drain_done
        endcase
    end

    // combinational outputs
    always_comb begin
        beat_in    = (state_q == ST_CAPTURE) && s_valid;
        push       = beat_in && !fifo_full;
        drop       = beat_in && fifo_full;
        push_last  = (cnt_q == LAST_IDX);
        final_beat = fifo_pop && (fifo_level == LVL_W'(1));
        busy       = (state_q != ST_IDLE);
    end

    // registered outputs and burst counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            trig_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            trig_q <= (state_q == ST_ARMED) && hit;
            if (state_q == ST_ARMED)
                cnt_q <= '0;
            else if (beat_in)
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_IDLE && arm)
                ovf_q <= 1'b0;
            else if (drop)
                ovf_q <= 1'b1;
        end
    end

    assign trig_pulse = trig_q;
    assign overflow   = ovf_q;

    assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    // R4: a pulse only follows a hit seen while armed
    assert_trig_from_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pulse) |-> $past(hit) && state_q == ST_CAPTURE);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(state_q == ST_IDLE && arm)) |=> overflow);
    assert_busy_from_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && arm) |=> busy);
endmodule

// File: rtl/thresh_capture.sv
module thresh_capture
    import tcap_pkg::*;
#(
    parameter int BURST_LEN  = 2000,
    parameter int FIFO_DEPTH = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic [15:0] threshold,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    output logic        trig_pulse,
    output logic        busy,
    output logic        overflow
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
    localparam int FW    = $bits(fifo_word_t);

    logic             hit, push, push_last, pop, full, empty;
    logic [LVL_W-1:0] level;
    fifo_word_t       wr_word, rd_word;

    assign s_tready = 1'b1;

    tcap_detect #(.CW(CH_W)) u_detect (
        .valid (s_tvalid),
        .beat  (s_tdata),
        .level (threshold),
        .hit   (hit)
    );

    tcap_ctrl #(.BURST_LEN(BURST_LEN), .LVL_W(LVL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .s_valid    (s_tvalid),
        .hit        (hit),
        .fifo_full  (full),
        .fifo_pop   (pop),
        .fifo_level (level),
        .push       (push),
        .push_last  (push_last),
        .trig_pulse (trig_pulse),
        .busy       (busy),
        .overflow   (overflow)
    );

    assign wr_word.data = s_tdata;
    assign wr_word.last = push_last;

    tcap_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_word),
        .pop   (pop),
        .dout  (rd_word),
        .full  (full),
        .empty (empty),
        .level (level)
    );

    assign m_tvalid = !empty;
    assign pop      = m_tvalid && m_tready;
    assign m_tdata  = rd_word.data;
    assign m_tlast  = m_tvalid && rd_word.last;

    assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
    assert_last_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> busy);
    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pop) && !m_tvalid);
endmodule

// File: tb/sim_thresh_capture.sv
module sim_thresh_capture;
    localparam int BL = 12;
    localparam int FD = 8;

    logic        clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
    logic [15:0] threshold = '0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0, m_tready = 1'b1;
    logic        s_tready, m_tvalid, m_tlast, trig_pulse, busy, overflow;
    logic [31:0] m_tdata;

    int checks = 0, failures = 0;
    int rmode = 0, rel = 0, cyc = 0;
    int nrx = 0, npulse = 0;
    logic [31:0] rx [64];
    logic        rxl [64];

    thresh_capture #(.BURST_LEN(BL), .FIFO_DEPTH(FD)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .threshold(threshold),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .trig_pulse(trig_pulse), .busy(busy), .overflow(overflow)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        m_tready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : (rel != 0);
    end

    always @(negedge clk) begin
        if (m_tvalid && m_tready && nrx < 64) begin
            rx[nrx]  = m_tdata;
            rxl[nrx] = m_tlast;
            nrx = nrx + 1;
        end
        if (trig_pulse) npulse = npulse + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_arm();
        @(posedge clk); #2 arm = 1'b1;
        @(posedge clk); #2 arm = 1'b0;
    endtask

    task automatic send_beat(input logic [31:0] w);
        @(posedge clk); #2 s_tvalid = 1'b1; s_tdata = w;
        @(posedge clk); #2 s_tvalid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    function automatic logic [31:0] bword(input int seed, input int j);
        return {16'(seed + j), 16'h7fff};
    endfunction

    task automatic feed_burst(input int seed, input bit gaps, input int extra);
        for (int j = 0; j < BL + extra; j++) begin
            @(posedge clk); #2 s_tvalid = 1'b1; s_tdata = bword(seed, j);
            if (gaps && j[0]) begin
                @(posedge clk); #2 s_tvalid = 1'b0;
            end
        end
        @(posedge clk); #2 s_tvalid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        failures = failures + 1;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        automatic int thr_list[5] = '{-30000, -1, 0, 77, 30000};
        automatic int seed = 100;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !m_tvalid && !trig_pulse && !overflow, "R2 reset state", busy, 0);
        chk(s_tready == 1'b1, "R1 reset ready", s_tready, 1);

        // crossing while idle: no effect
        threshold = 16'd0;
        send_beat({16'h7fff, 16'h7fff});
        @(negedge clk);
        chk(!trig_pulse && !busy, "R4 idle crossing", trig_pulse, 0);

        for (int ti = 0; ti < 5; ti++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int d = -2; d <= 2; d++) begin
                    automatic int v = thr_list[ti] + d;
                    automatic bit exp = (v > thr_list[ti]);
                    automatic logic [31:0] w;
                    w = (ch == 0) ? {16'h8000, 16'(v)} : {16'(v), 16'h8000};
                    threshold = 16'(thr_list[ti]);
                    rmode = (ti + d + 2) % 2;
                    pulse_arm();
                    @(negedge clk);
                    chk(busy && !overflow, "R2 arm accepted", busy, 1);
                    npulse = 0;
                    @(posedge clk); #2 s_tvalid = 1'b1; s_tdata = w;
                    @(posedge clk); #2 s_tvalid = 1'b0;
                    @(negedge clk);
                    chk(trig_pulse == exp, "R3 pulse after crossing", trig_pulse, exp);
                    if (!exp) begin
                        send_beat({16'h0000, 16'h7fff});
                        @(negedge clk);
                        chk(trig_pulse == 1'b1, "R3 forced crossing", trig_pulse, 1);
                    end
                    nrx = 0;
                    feed_burst(seed, rmode == 1, 2);
                    wait_idle();
                    chk(nrx == BL, "R5 burst length", nrx, BL);
                    for (int j = 0; j < BL && j < nrx; j++) begin
                        chk(rx[j] == bword(seed, j), "R5 burst data", rx[j], bword(seed, j));
                        chk(rxl[j] == (j == BL - 1), "R6 tlast position", rxl[j], j == BL - 1);
                    end
                    chk(npulse == 1, "R4 single pulse per capture", npulse, 1);
                    chk(!overflow, "R7 no overflow when deep enough", overflow, 0);
                    send_beat({16'h7fff, 16'h7fff});
                    @(negedge clk);
                    chk(!trig_pulse && !busy, "R9 no retrigger without arm", trig_pulse, 0);
                    seed = seed + 37;
                end
            end
        end

        // overflow: hold the sink off during the whole burst
        threshold = 16'd0;
        rmode = 2; rel = 0;
        pulse_arm();
        send_beat({16'h0000, 16'h0001});
        nrx = 0;
        for (int j = 0; j < BL; j++) begin
            @(posedge clk); #2 s_tvalid = 1'b1; s_tdata = bword(seed, j);
            @(negedge clk);
            chk(s_tready == 1'b1, "R1 ready under backpressure", s_tready, 1);
        end
        @(posedge clk); #2 s_tvalid = 1'b0;
        @(negedge clk);
        chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
        chk(m_tvalid && m_tdata == bword(seed, 0), "R7 stalled head held", m_tdata, bword(seed, 0));
        pulse_arm();
        @(negedge clk);
        chk(overflow && busy, "R2 arm ignored while busy", overflow, 1);
        rel = 1;
        wait_idle();
        chk(nrx == FD, "R8 stored beats delivered", nrx, FD);
        for (int j = 0; j < FD && j < nrx; j++) begin
            chk(rx[j] == bword(seed, j), "R8 kept data", rx[j], bword(seed, j));
            chk(rxl[j] == 1'b0, "R8 no tlast after dropped end", rxl[j], 0);
        end
        chk(!busy, "R9 idle after drain", busy, 0);
        rmode = 0;
        pulse_arm();
        @(negedge clk);
        chk(!overflow, "R8 arm clears overflow", overflow, 0);
        send_beat({16'h0000, 16'h0005});
        nrx = 0;
        feed_burst(seed, 1'b0, 0);
        wait_idle();
        chk(nrx == BL && rxl[BL-1], "R6 final capture complete", nrx, BL);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule